// File: doc/BRIEF.md
# Staggered Two-Input Cell Array

This block is a grid of ROWS by COLS identical cells. Each cell takes two bits, produces two bits and carries no state apart from a 3-bit operation code, its flavor. Some flavors only steer bits (straight through, swapped, one side copied to both). The others compute (half adder, AND, OR). A bit vector of 2*COLS bits enters the first row. Each following row sees the previous row's outputs moved sideways by half a cell, so every cell of one row feeds two neighbouring cells of the next. Bits only ever move forward to the next row.

Each row ends in a register, so the array is a pipeline of ROWS stages and accepts a new vector every clock. A valid flag travels alongside the data. A write port sets one cell's flavor per clock. It does so only while the pipeline holds nothing and no vector is being offered. Typical use is to load the flavors once, then stream vectors through.

Top module: `origami_array`

## Requirements
- R1: After reset, out_valid and out_data are 0 and every cell holds flavor 0 (straight through).
- R2: Flavor 0 copies left input to left output and right to right. Flavor 1 swaps them: left input to right output, right input to left output.
- R3: Flavor 2 drives both outputs from the left input. Flavor 3 drives both outputs from the right input. The other input has no effect.
- R4: Flavor 4 is a half adder: the sum goes on the left output and the carry on the right output.
- R5: Flavor 5 puts the AND of the two inputs on the left output. Flavor 6 puts the OR there. Both drive 0 on the right output. Flavor 7 drives 0 on both outputs.
- R6: In every row bus, cell c uses bit 2c as its left pin and bit 2c+1 as its right pin. Row 0 takes in_data bits directly.
- R7: Row r (r odd) takes bus bit k from bit k-1 of row r-1's outputs. Row r (r even, r>0) takes bit k from bit k+1. An input with no driver at an edge reads 0.
- R8: Every row is registered. A vector sampled with in_valid at one rising edge appears on out_data with out_valid high ROWS-1 rising edges later, one result per input, in order.
- R9: A write with cfg_we high sets cell (cfg_row, cfg_col) to cfg_code at the clock edge.
- R10: A write is ignored while the array is busy, meaning in_valid is high or any row holds a valid vector.
- R11: A write whose cfg_row is at least ROWS, or whose cfg_col is at least COLS, changes no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Flavor write strobe |
| cfg_row | input | ROW_IDX_W | Row index of the written cell |
| cfg_col | input | COL_IDX_W | Column index of the written cell |
| cfg_code | input | 3 | Flavor code to store |
| in_valid | input | 1 | in_data holds a vector this cycle |
| in_data | input | 2*COLS | Input vector for row 0 |
| out_valid | output | 1 | out_data holds a result |
| out_data | output | 2*COLS | Last row's registered outputs |

## Verification
The bench sends every 8-bit vector through a mixed flavor map. The edge bits are the target: a design that wrapped the stagger or shifted every row the same way would hand the wrong neighbour's bit to the outer cells. A write is placed in the cycle after a vector enters. A design that let it through would change the next result. A write to row 4 is also sent. A design that truncated the index would overwrite row 0. Back-to-back vectors expose a pipeline that drops, repeats or delays a result, because out_valid and out_data are compared on every clock.

// File: rtl/origami_pkg.sv
package origami_pkg;

  localparam int FLAVOR_W = 3;

  typedef enum logic [FLAVOR_W-1:0] {
    FL_PASS     = 3'd0,
    FL_CROSS    = 3'd1,
    FL_BCAST_L  = 3'd2,
    FL_BCAST_R  = 3'd3,
    FL_HALF_ADD = 3'd4,
    FL_AND      = 3'd5,
    FL_OR       = 3'd6,
    FL_ZERO     = 3'd7
  } flavor_e;

  typedef struct packed {
    logic right;
    logic left;
  } pair_t;

  // Pure combinational behaviour of one cell.
  function automatic pair_t cell_eval(flavor_e fl, logic a_l, logic a_r);
    pair_t res;
    res = '0;
    case (fl)
      FL_PASS:     begin res.left = a_l;       res.right = a_r;       end
      FL_CROSS:    begin res.left = a_r;       res.right = a_l;       end
      FL_BCAST_L:  begin res.left = a_l;       res.right = a_l;       end
      FL_BCAST_R:  begin res.left = a_r;       res.right = a_r;       end
      FL_HALF_ADD: begin res.left = a_l ^ a_r; res.right = a_l & a_r; end
      FL_AND:      begin res.left = a_l & a_r; res.right = 1'b0;      end
      FL_OR:       begin res.left = a_l | a_r; res.right = 1'b0;      end
      default:     res = '0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/origami_cell.sv
module origami_cell
  import origami_pkg::*;
(
  input  logic [FLAVOR_W-1:0] code,
  input  logic                in_l,
  input  logic                in_r,
  output logic                out_l,
  output logic                out_r
);

  pair_t res;

  always_comb begin
    res   = cell_eval(flavor_e'(code), in_l, in_r);
    out_l = res.left;
    out_r = res.right;
  end

endmodule

// File: rtl/origami_cfg_store.sv
module origami_cfg_store
  import origami_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic                            busy,
  input  logic [ROW_IDX_W-1:0]            row,
  input  logic [COL_IDX_W-1:0]            col,
  input  logic [FLAVOR_W-1:0]             code,
  output logic [ROWS*COLS*FLAVOR_W-1:0]   cfg_flat
);

  logic in_range;
  logic wr_ok;

  assign in_range = (row < ROW_IDX_W'(ROWS)) && (col < COL_IDX_W'(COLS));
  assign wr_ok    = we && !busy && in_range;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int BASE = (r * COLS + c) * FLAVOR_W;
      logic hit;
      assign hit = wr_ok && (row == ROW_IDX_W'(r)) && (col == COL_IDX_W'(c));
      always_ff @(posedge clk) begin
        if (!rst_n)   cfg_flat[BASE +: FLAVOR_W] <= FL_PASS;
        else if (hit) cfg_flat[BASE +: FLAVOR_W] <= code;
      end
    end
  end

  // R11: an address outside the grid leaves every cell as it was
  assert_range_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !in_range) |=> $stable(cfg_flat));

endmodule

// File: rtl/origami_row.sv
module origami_row
  import origami_pkg::*;
#(
  parameter int COLS  = 4,
  parameter int SHIFT = 0   // 0: direct, 1: toward higher bits, 2: toward lower bits
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prev_valid,
  input  logic [2*COLS-1:0]        prev_data,
  input  logic [COLS*FLAVOR_W-1:0] codes,
  output logic                     row_valid,
  output logic [2*COLS-1:0]        row_data
);

  localparam int W = 2 * COLS;

  logic [W-1:0] feed;
  logic [W-1:0] cell_out;

  // Half-cell stagger between rows; the bit pushed off the edge is dropped.
  if (SHIFT == 1) begin : g_up
    logic edge_unused;
    assign edge_unused = prev_data[W-1];
    assign feed = {prev_data[W-2:0], 1'b0};
  end else if (SHIFT == 2) begin : g_down
    logic edge_unused;
    assign edge_unused = prev_data[0];
    assign feed = {1'b0, prev_data[W-1:1]};
  end else begin : g_direct
    assign feed = prev_data;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_cell
    logic [FLAVOR_W-1:0] code_c;
    logic                fl, fr, ol, orr;
    assign code_c = codes[c*FLAVOR_W +: FLAVOR_W];
    assign fl = feed[2*c];
    assign fr = feed[2*c+1];
    assign ol = cell_out[2*c];
    assign orr = cell_out[2*c+1];

    origami_cell u_cell (
      .code  (code_c),
      .in_l  (fl),
      .in_r  (fr),
      .out_l (cell_out[2*c]),
      .out_r (cell_out[2*c+1])
    );

    // R2: a swap cell exchanges sides
    assert_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (code_c == FL_CROSS) |-> (ol == fr && orr == fl));
    // R3: a broadcast cell shows the same bit on both outputs
    assert_bcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (code_c == FL_BCAST_L || code_c == FL_BCAST_R) |-> (ol == orr));
    // R4: carry and sum together equal the arithmetic sum of the inputs
    assert_half_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (code_c == FL_HALF_ADD) |-> ({orr, ol} == ({1'b0, fl} + {1'b0, fr})));
    // R5: the spare code is silent
    assert_zero_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (code_c == FL_ZERO) |-> (ol == 1'b0 && orr == 1'b0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_valid <= 1'b0;
      row_data  <= '0;
    end else begin
      row_valid <= prev_valid;
      row_data  <= cell_out;
    end
  end

endmodule

// File: rtl/origami_array.sv
module origami_array
  import origami_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int ROW_IDX_W = $clog2(ROWS) + 1,
  parameter int COL_IDX_W = $clog2(COLS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ROW_IDX_W-1:0] cfg_row,
  input  logic [COL_IDX_W-1:0] cfg_col,
  input  logic [2:0]           cfg_code,
  input  logic                 in_valid,
  input  logic [2*COLS-1:0]    in_data,
  output logic                 out_valid,
  output logic [2*COLS-1:0]    out_data
);

  localparam int W     = 2 * COLS;
  localparam int ROW_CFG_W = COLS * FLAVOR_W;
  localparam int CFG_W = ROWS * ROW_CFG_W;

  logic [ROWS-1:0]         stage_valid;
  logic [ROWS-1:0][W-1:0]  stage_data;
  logic [CFG_W-1:0]        cfg_flat;
  logic                    busy;

  assign busy = in_valid | (|stage_valid);

  origami_cfg_store #(
    .ROWS(ROWS), .COLS(COLS), .ROW_IDX_W(ROW_IDX_W), .COL_IDX_W(COL_IDX_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .busy     (busy),
    .row      (cfg_row),
    .col      (cfg_col),
    .code     (cfg_code),
    .cfg_flat (cfg_flat)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_stage
    localparam int SH = (r == 0) ? 0 : ((r % 2 == 1) ? 1 : 2);
    logic         pv;
    logic [W-1:0] pd;
    if (r == 0) begin : g_first
      assign pv = in_valid;
      assign pd = in_data;
    end else begin : g_next
      assign pv = stage_valid[r-1];
      assign pd = stage_data[r-1];
    end

    origami_row #(.COLS(COLS), .SHIFT(SH)) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .prev_valid (pv),
      .prev_data  (pd),
      .codes      (cfg_flat[r*ROW_CFG_W +: ROW_CFG_W]),
      .row_valid  (stage_valid[r]),
      .row_data   (stage_data[r])
    );
  end

  assign out_valid = stage_valid[ROWS-1];
  assign out_data  = stage_data[ROWS-1];

  // R10: flavors cannot move while a vector is offered or in flight
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_flat));
  // R8: an empty pipeline produces no result on the next cycle
  assert_no_phantom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !out_valid);

endmodule

// File: tb/origami_array_test.sv
module origami_array_test;

  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int W    = 2 * COLS;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_row = '0;
  logic [2:0]   cfg_col = '0;
  logic [2:0]   cfg_code = '0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic [W-1:0] out_data;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string cur_tag = "R1";

  // model state
  int           mcfg [ROWS][COLS];
  bit           mv [ROWS];
  logic [W-1:0] md [ROWS];

  always #5 clk = ~clk;

  origami_array #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_col(cfg_col), .cfg_code(cfg_code), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic void flav(input int code, input int a, input int b,
                               output int lo, output int ro);
    case (code)
      0: begin lo = a; ro = b; end
      1: begin lo = b; ro = a; end
      2: begin lo = a; ro = a; end
      3: begin lo = b; ro = b; end
      4: begin lo = (a + b) % 2; ro = (a + b) / 2; end
      5: begin lo = a * b; ro = 0; end
      6: begin lo = (a + b > 0) ? 1 : 0; ro = 0; end
      default: begin lo = 0; ro = 0; end
    endcase
  endfunction

  function automatic logic [W-1:0] model_eval(input logic [W-1:0] v);
    int cur [W];
    int inb [W];
    int lo, ro;
    for (int k = 0; k < W; k++) cur[k] = int'(v[k]);
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < W; k++) begin
        if (r == 0) inb[k] = cur[k];
        else if (r % 2 == 1) inb[k] = (k > 0) ? cur[k-1] : 0;
        else inb[k] = (k < W - 1) ? cur[k+1] : 0;
      end
      for (int c = 0; c < COLS; c++) begin
        flav(mcfg[r][c], inb[2*c], inb[2*c+1], lo, ro);
        cur[2*c] = lo;
        cur[2*c+1] = ro;
      end
    end
    for (int k = 0; k < W; k++) model_eval[k] = (cur[k] != 0);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        mv[r] = 0; md[r] = '0;
        for (int c = 0; c < COLS; c++) mcfg[r][c] = 0;
      end
    end else begin
      bit busy_m;
      busy_m = in_valid;
      for (int r = 0; r < ROWS; r++) if (mv[r]) busy_m = 1;
      for (int r = ROWS - 1; r > 0; r--) begin
        mv[r] = mv[r-1]; md[r] = md[r-1];
      end
      mv[0] = in_valid;
      md[0] = in_valid ? model_eval(in_data) : '0;
      if (cfg_we && !busy_m && cfg_row < ROWS && cfg_col < COLS)
        mcfg[cfg_row][cfg_col] = cfg_code;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (out_valid !== mv[ROWS-1]) begin
        mismatched++;
        $display("FAIL %s out_valid actual %0b expected %0b", cur_tag, out_valid, mv[ROWS-1]);
      end else if (mv[ROWS-1] && out_data !== md[ROWS-1]) begin
        mismatched++;
        $display("FAIL %s out_data actual %02h expected %02h", cur_tag, out_data, md[ROWS-1]);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // R9: single-cell flavor write
  task automatic wr(input int r, input int c, input int code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 3'(r); cfg_col = 3'(c); cfg_code = 3'(code);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [W-1:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_data = v;
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0; in_data = '0;
    repeat (ROWS + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    compared++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      mismatched++;
      $display("FAIL R1 reset actual %0b/%02h expected 0/00", out_valid, out_data);
    end

    cur_tag = "R1";  send(8'hFF); send(8'h00); drain();
    cur_tag = "R6";  send(8'h01); send(8'h80); send(8'h81); drain();
    cur_tag = "R7";  send(8'h5A); send(8'hA5); send(8'h3C); drain();
    cur_tag = "R8";
    for (int i = 0; i < 12; i++) send(8'(i * 23 + 1));
    drain();

    cur_tag = "R2";
    for (int c = 0; c < COLS; c++) wr(0, c, 1);
    send(8'h01); send(8'h12); send(8'hC3); drain();

    cur_tag = "R3";
    wr(1, 0, 2); wr(1, 1, 3); wr(1, 2, 2); wr(1, 3, 3);
    send(8'h0F); send(8'hF0); send(8'h66); send(8'h99); drain();

    cur_tag = "R4";
    for (int c = 0; c < COLS; c++) wr(2, c, 4);
    for (int i = 0; i < 16; i++) send(8'(i * 17));
    drain();

    cur_tag = "R5";
    wr(3, 0, 5); wr(3, 1, 6); wr(3, 2, 7); wr(3, 3, 5);
    for (int i = 0; i < 256; i++) send(8'(i));
    drain();

    cur_tag = "R9";
    wr(0, 0, 0); wr(2, 3, 6); wr(3, 2, 4);
    for (int i = 0; i < 32; i++) send(8'(i * 7 + 3));
    drain();

    // R10: write offered while a vector is in flight must not land
    cur_tag = "R10";
    send(8'hFF);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_row = 3'd0; cfg_col = 3'd0; cfg_code = 3'd7;
    @(negedge clk);
    cfg_we = 1'b0;
    drain();
    send(8'hFF); send(8'h03); drain();

    // R11: row index beyond the grid changes nothing
    cur_tag = "R11";
    wr(4, 0, 7); wr(0, 5, 7);
    send(8'hFF); send(8'h03); send(8'hC0); drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule